// File: doc/BRIEF.md
# Receive Packet Queue with Word Readout

This block takes incoming Ethernet frames as a byte stream and keeps them in a circular set of packet slots in one word-wide memory. As a frame arrives, the block runs a CRC-32 over the payload. At the end of the frame it writes a slot image made of a two-byte length, the payload, the four CRC bytes and zero fill up to the word boundary. The frame becomes visible to the host only after its last byte has been taken.

The host drains the queue through a single data port. Each read strobe returns the next four stored bytes as one little-endian word. Once the last word of a packet has been read, the queue moves on to the next slot by itself. A control byte sets receive enable and can flush the queue. The host can see the number of packets waiting at all times, and a sticky flag reports each packet stored. Frames that arrive while reception is off, while every slot is full, or that are too big for a slot are thrown away without a trace.

Top module: `rx_pkt_queue`

## Requirements
- R1: While control bit 0 (receive enable) is 0 when a frame's first byte arrives, the frame is discarded: `pending` and `irq_rx` stay unchanged.
- R2: A frame whose first byte arrives while `pending` equals NUM_SLOTS (default 31) is discarded and `pending` stays at NUM_SLOTS.
- R3: The image of a stored packet with P payload bytes is: byte 0 = low byte of P+6, byte 1 = high byte of P+6, bytes 2 to P+1 = the payload in arrival order, and then four CRC bytes with the least significant byte first.
- R4: The CRC is the reflected CRC-32 (polynomial 0xEDB88320). It starts from 0xFFFFFFFF, runs over the payload bytes only, and is complemented at the end.
- R5: Bytes of the last word that lie past the image length P+6 read as zero.
- R6: A `data_rd` strobe with at least one packet pending gives, one cycle later with `rd_valid` high, the next four image bytes packed little-endian (lowest address in bits 7:0). The read of a packet's last word, ceil((P+6)/4), decrements `pending`, and the next read starts the following slot. The slot index wraps from NUM_SLOTS-1 to 0.
- R7: A `data_rd` strobe with `pending` at 0 returns 0 and changes neither the queue nor the read position.
- R8: Storing a packet increments `pending` and sets `irq_rx`. Both appear six rising edges after the edge that takes the last byte. `irq_ack` clears `irq_rx`, and a new store wins over a clear in the same cycle.
- R9: A control write with bit 4 set sets `pending` to 0, drops any packet partly read, and aborts a frame being stored. The next frame is stored and read from its first word. Bit 4 reads back as 0 on `ctl_q`, while the other bits hold the value written.
- R10: A frame whose payload is larger than SLOT_BYTES-6 is discarded. A payload of exactly SLOT_BYTES-6 is stored and reads back as SLOT_BYTES/4 words.
- R11: A frame changes `pending` only after its last byte, never while its bytes are still arriving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | 8 | Incoming byte |
| rx_last | input | 1 | Marks the last byte of a frame |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte: bit 0 receive enable, bit 4 flush |
| irq_ack | input | 1 | Clears the packet-stored flag |
| data_rd | input | 1 | Data word read strobe |
| ctl_q | output | 8 | Control byte read-back (bit 4 always 0) |
| rd_data | output | 32 | Word returned for the previous read strobe |
| rd_valid | output | 1 | High the cycle after a read strobe |
| pending | output | $clog2(NUM_SLOTS+1) | Number of stored packets not yet fully read |
| irq_rx | output | 1 | Sticky packet-stored flag |

## Verification
Each result is due a fixed number of cycles after its stimulus. A read word appears in the cycle after the strobe, together with any decrement of `pending`. A stored frame shows up six rising edges after its last byte. The bench drives on falling edges and samples read data at the falling edge that follows the strobe. After each frame it waits eight cycles before it looks at `pending` or `irq_rx`, and it checks `pending` just before the last byte to confirm that nothing was committed early. Expected words come from a separate model in the bench that builds the length, payload, CRC and zero fill.

// File: rtl/rxq_pkg.sv
// Package rxq_pkg
// Holds the types and the CRC step function that the receive queue modules share.
// Assumes: bytes go through the CRC least significant bit first (reflected form).
package rxq_pkg;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_RECV,
        WS_DROP,
        WS_CRC,
        WS_PAD,
        WS_HDR
    } wr_state_t;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
    localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;

    // Takes one byte into a running reflected CRC-32 (no final complement here).
    function automatic logic [31:0] crc32_byte(input logic [31:0] crc_in,
                                               input logic [7:0]  b);
        logic [31:0] c;
        c = crc_in ^ {24'b0, b};
        for (int k = 0; k < 8; k++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/rxq_mem.sv
// Module rxq_mem
// Word-wide slot storage with one write port and one registered read port.
// Assumes: the read data for a given address shows up the cycle after it is presented.
module rxq_mem #(
    parameter int DEPTH  = 1984,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [31:0]       wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [31:0]       rdata
);

    logic [31:0] store [DEPTH];

    // Write port.
    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        rdata <= store[raddr];
    end

endmodule

// File: rtl/rxq_writer.sv
// Module rxq_writer
// Packs the incoming bytes into a slot image. The two header bytes are filled in last,
// because the length is only known at the end of the frame.
// After the last byte it spends four cycles on CRC bytes, one on the partial tail word
// and one on the header word, and then raises commit.
// Assumes: at least eight idle cycles between frames. Bytes that arrive while the
// frame is being finished are ignored.
module rxq_writer
    import rxq_pkg::*;
#(
    parameter int NUM_SLOTS  = 31,
    parameter int SLOT_BYTES = 256,
    localparam int WPS    = SLOT_BYTES / 4,
    localparam int DEPTH  = NUM_SLOTS * WPS,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int SLOT_W = $clog2(NUM_SLOTS),
    localparam int OFF_W  = $clog2(SLOT_BYTES) + 1,
    localparam int NW_W   = $clog2(WPS) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    input  logic              start_ok,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic              abort,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [31:0]       mem_wdata,
    output logic              commit,
    output logic [SLOT_W-1:0] commit_slot,
    output logic [NW_W-1:0]   commit_nw
);

    wr_state_t         state;
    logic [SLOT_W-1:0] slot_q;
    logic [OFF_W-1:0]  off;
    logic [31:0]       crc;
    logic [15:0]       hdr_hi;
    logic [31:0]       wbuf;
    logic              ovf;
    logic [1:0]        crc_idx;

    logic [OFF_W-1:0]  cur_off;
    logic [1:0]        lane;
    logic              push_en;
    logic [7:0]        push_b;
    logic [31:0]       crc_fin;
    logic [ADDR_W-1:0] slot_base;

    // Picks the byte to store this cycle and where it lands.
    always_comb begin
        cur_off   = (state == WS_IDLE) ? OFF_W'(2) : off;
        lane      = cur_off[1:0];
        crc_fin   = ~crc;
        slot_base = ADDR_W'(slot_q) * ADDR_W'(WPS);
        push_en   = 1'b0;
        push_b    = rx_data;
        case (state)
            WS_IDLE: push_en = rx_valid && start_ok;
            WS_RECV: push_en = rx_valid && !ovf && (cur_off < OFF_W'(SLOT_BYTES - 4));
            WS_CRC: begin
                push_en = 1'b1;
                push_b  = crc_fin[{crc_idx, 3'b000} +: 8];
            end
            default: push_en = 1'b0;
        endcase
    end

    // Memory write port: full body words, the zero-filled tail word, then the header word.
    always_comb begin
        mem_we    = 1'b0;
        mem_waddr = slot_base + ADDR_W'(cur_off >> 2);
        mem_wdata = {push_b, wbuf[23:0]};
        if (push_en && (lane == 2'd3) && (cur_off >= OFF_W'(4))) begin
            mem_we = 1'b1;
        end
        if (state == WS_PAD) begin
            mem_we    = (lane != 2'd0);
            mem_wdata = wbuf;
        end
        if (state == WS_HDR) begin
            mem_we    = 1'b1;
            mem_waddr = slot_base;
            mem_wdata = {hdr_hi, 16'(off)};
        end
    end

    // Hand-off of the finished packet to the read side.
    always_comb begin
        commit      = (state == WS_HDR) && !abort;
        commit_slot = slot_q;
        commit_nw   = NW_W'((off + OFF_W'(3)) >> 2);
    end

    // Frame state, byte packing and running CRC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= WS_IDLE;
            slot_q  <= '0;
            off     <= '0;
            crc     <= CRC_SEED;
            hdr_hi  <= '0;
            wbuf    <= '0;
            ovf     <= 1'b0;
            crc_idx <= '0;
        end else if (abort) begin
            state <= WS_IDLE;
            ovf   <= 1'b0;
        end else begin
            if (push_en) begin
                if (cur_off < OFF_W'(4)) begin
                    hdr_hi[{lane[0], 3'b000} +: 8] <= push_b;
                end else if (lane == 2'd0) begin
                    wbuf <= {24'b0, push_b};
                end else begin
                    wbuf[{lane, 3'b000} +: 8] <= push_b;
                end
                off <= cur_off + OFF_W'(1);
            end
            case (state)
                WS_IDLE: begin
                    if (rx_valid) begin
                        if (start_ok) begin
                            slot_q  <= wr_slot;
                            crc     <= crc32_byte(CRC_SEED, rx_data);
                            ovf     <= 1'b0;
                            crc_idx <= '0;
                            state   <= rx_last ? WS_CRC : WS_RECV;
                        end else if (!rx_last) begin
                            state <= WS_DROP;
                        end
                    end
                end
                WS_RECV: begin
                    if (rx_valid) begin
                        if (push_en) begin
                            crc <= crc32_byte(crc, rx_data);
                        end else begin
                            ovf <= 1'b1;
                        end
                        if (rx_last) begin
                            crc_idx <= '0;
                            state   <= (ovf || !push_en) ? WS_IDLE : WS_CRC;
                        end
                    end
                end
                WS_DROP: if (rx_valid && rx_last) state <= WS_IDLE;
                WS_CRC: begin
                    crc_idx <= crc_idx + 2'd1;
                    if (crc_idx == 2'd3) state <= WS_PAD;
                end
                WS_PAD:  state <= WS_HDR;
                default: state <= WS_IDLE;
            endcase
        end
    end

    // R10: a committed image always holds the header and CRC and fits in its slot.
    a_r10_len_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (off >= OFF_W'(6)) && (off <= OFF_W'(SLOT_BYTES)));

    // R11: a commit always follows a tail-word cycle.
    a_r11_commit_after_tail: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(state) == WS_PAD);

endmodule

// File: rtl/rxq_reader.sv
// Module rxq_reader
// Keeps the read slot, the word position inside it and the pending count, and
// stores the word count of each slot as it is committed.
// Derives the write slot as read slot plus pending, modulo NUM_SLOTS.
// Assumes: no commit arrives when pending is already NUM_SLOTS.
module rxq_reader #(
    parameter int NUM_SLOTS  = 31,
    parameter int SLOT_BYTES = 256,
    localparam int WPS    = SLOT_BYTES / 4,
    localparam int DEPTH  = NUM_SLOTS * WPS,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int SLOT_W = $clog2(NUM_SLOTS),
    localparam int WIDX_W = $clog2(WPS),
    localparam int NW_W   = WIDX_W + 1,
    localparam int PEND_W = $clog2(NUM_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_rd,
    input  logic              flush,
    input  logic              commit,
    input  logic [SLOT_W-1:0] commit_slot,
    input  logic [NW_W-1:0]   commit_nw,
    output logic [ADDR_W-1:0] mem_raddr,
    input  logic [31:0]       mem_rdata,
    output logic [31:0]       rd_data,
    output logic              rd_valid,
    output logic [PEND_W-1:0] pending,
    output logic [SLOT_W-1:0] wr_slot
);

    logic [SLOT_W-1:0] rd_slot;
    logic [WIDX_W-1:0] widx;
    logic [NW_W-1:0]   nw_tab [NUM_SLOTS];
    logic              rd_zero;

    logic              have;
    logic              do_rd;
    logic              last_w;
    logic              done;
    int                slot_sum;

    // Read address, end-of-packet detect and write slot.
    always_comb begin
        have      = (pending != '0);
        do_rd     = data_rd && have;
        last_w    = ((NW_W'(widx) + NW_W'(1)) == nw_tab[rd_slot]);
        done      = do_rd && last_w;
        mem_raddr = ADDR_W'(rd_slot) * ADDR_W'(WPS) + ADDR_W'(widx);
        slot_sum  = int'(rd_slot) + int'(pending);
        if (slot_sum >= NUM_SLOTS) slot_sum = slot_sum - NUM_SLOTS;
        wr_slot   = SLOT_W'(slot_sum);
        rd_data   = rd_zero ? 32'b0 : mem_rdata;
    end

    // Records the word count of each slot as it is committed.
    always_ff @(posedge clk) begin
        if (commit) begin
            nw_tab[commit_slot] <= commit_nw;
        end
    end

    // Read position, pending count and read strobe timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_slot  <= '0;
            widx     <= '0;
            pending  <= '0;
            rd_zero  <= 1'b1;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= data_rd;
            rd_zero  <= !have;
            if (flush) begin
                pending <= '0;
                widx    <= '0;
            end else begin
                pending <= pending + PEND_W'(commit) - PEND_W'(done);
                if (do_rd) begin
                    if (last_w) begin
                        widx    <= '0;
                        rd_slot <= (rd_slot == SLOT_W'(NUM_SLOTS - 1)) ? '0 : rd_slot + SLOT_W'(1);
                    end else begin
                        widx <= widx + WIDX_W'(1);
                    end
                end
            end
        end
    end

    // R2: the queue never holds more than NUM_SLOTS packets.
    a_r2_pending_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pending <= PEND_W'(NUM_SLOTS));

    // R6: without a flush the count moves by at most one per cycle.
    a_r6_pending_step: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> (pending == $past(pending)) || (pending == $past(pending) + PEND_W'(1))
                   || (pending == $past(pending) - PEND_W'(1)));

    // R7: a read of an empty queue leaves slot and count alone.
    a_r7_empty_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !have && !flush && !commit) |=> (pending == '0) && $stable(rd_slot));

    // R7: the word returned for an empty read is zero.
    a_r7_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !have) |=> (rd_data == 32'b0));

    // R9: a flush empties the queue.
    a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (pending == '0));

endmodule

// File: rtl/rx_pkt_queue.sv
// Module rx_pkt_queue
// Top of the receive packet queue. Holds the control byte and the packet-stored flag,
// and connects the writer, the slot memory and the reader.
// Assumes: SLOT_BYTES is a power of two between 16 and 65532, and frames are
// separated by at least eight idle cycles.
module rx_pkt_queue #(
    parameter int NUM_SLOTS  = 31,
    parameter int SLOT_BYTES = 256,
    localparam int WPS    = SLOT_BYTES / 4,
    localparam int DEPTH  = NUM_SLOTS * WPS,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int SLOT_W = $clog2(NUM_SLOTS),
    localparam int NW_W   = $clog2(WPS) + 1,
    localparam int PEND_W = $clog2(NUM_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    input  logic              ctl_wr,
    input  logic [7:0]        ctl_wdata,
    input  logic              irq_ack,
    input  logic              data_rd,
    output logic [7:0]        ctl_q,
    output logic [31:0]       rd_data,
    output logic              rd_valid,
    output logic [PEND_W-1:0] pending,
    output logic              irq_rx
);

    localparam int CTL_EN_BIT    = 0;
    localparam int CTL_FLUSH_BIT = 4;

    logic              flush;
    logic              start_ok;
    logic [SLOT_W-1:0] wr_slot;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [31:0]       mem_wdata;
    logic [ADDR_W-1:0] mem_raddr;
    logic [31:0]       mem_rdata;
    logic              commit;
    logic [SLOT_W-1:0] commit_slot;
    logic [NW_W-1:0]   commit_nw;

    // Flush pulse and the admission decision for a new frame.
    always_comb begin
        flush    = ctl_wr && ctl_wdata[CTL_FLUSH_BIT];
        start_ok = ctl_q[CTL_EN_BIT] && (pending < PEND_W'(NUM_SLOTS));
    end

    // Control byte register; the flush bit does not stay set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= 8'h00;
        end else if (ctl_wr) begin
            ctl_q <= ctl_wdata & ~(8'h01 << CTL_FLUSH_BIT);
        end
    end

    // Sticky packet-stored flag; a new store takes priority over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_rx <= 1'b0;
        end else if (commit) begin
            irq_rx <= 1'b1;
        end else if (irq_ack) begin
            irq_rx <= 1'b0;
        end
    end

    rxq_writer #(.NUM_SLOTS(NUM_SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_writer (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .rx_last     (rx_last),
        .start_ok    (start_ok),
        .wr_slot     (wr_slot),
        .abort       (flush),
        .mem_we      (mem_we),
        .mem_waddr   (mem_waddr),
        .mem_wdata   (mem_wdata),
        .commit      (commit),
        .commit_slot (commit_slot),
        .commit_nw   (commit_nw)
    );

    rxq_mem #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    rxq_reader #(.NUM_SLOTS(NUM_SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_reader (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_rd     (data_rd),
        .flush       (flush),
        .commit      (commit),
        .commit_slot (commit_slot),
        .commit_nw   (commit_nw),
        .mem_raddr   (mem_raddr),
        .mem_rdata   (mem_rdata),
        .rd_data     (rd_data),
        .rd_valid    (rd_valid),
        .pending     (pending),
        .wr_slot     (wr_slot)
    );

    // R8: every store raises the flag.
    a_r8_flag_on_store: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> irq_rx);

    // R1: no store can start with receive turned off.
    a_r1_no_store_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q[CTL_EN_BIT] && !ctl_wr) |=> !(start_ok));

endmodule

// File: tb/tb_rx_pkt_queue.sv
// Bench for rx_pkt_queue: directed corner cases plus seeded random frames, compared
// against word images built by the bench's own model.
module tb_rx_pkt_queue;

    localparam int NS     = 31;
    localparam int SB     = 256;
    localparam int PEND_W = $clog2(NS + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rx_valid = 1'b0;
    logic [7:0]        rx_data = 8'h00;
    logic              rx_last = 1'b0;
    logic              ctl_wr = 1'b0;
    logic [7:0]        ctl_wdata = 8'h00;
    logic              irq_ack = 1'b0;
    logic              data_rd = 1'b0;
    logic [7:0]        ctl_q;
    logic [31:0]       rd_data;
    logic              rd_valid;
    logic [PEND_W-1:0] pending;
    logic              irq_rx;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [7:0]  pay [0:SB];
    logic [31:0] exp_w[$];
    int          exp_n[$];

    always #5 clk = ~clk;

    rx_pkt_queue #(.NUM_SLOTS(NS), .SLOT_BYTES(SB)) dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .irq_ack(irq_ack), .data_rd(data_rd), .ctl_q(ctl_q), .rd_data(rd_data),
        .rd_valid(rd_valid), .pending(pending), .irq_rx(irq_rx)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            c = c ^ {24'b0, pay[i]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        return ~c;
    endfunction

    // Builds the expected word image of a stored frame of n payload bytes.
    task automatic expect_frame(input int n);
        logic [7:0]  bb [0:SB+3];
        logic [15:0] l16 = 16'(n + 6);
        logic [31:0] c = ref_crc(n);
        int nw = (n + 6 + 3) / 4;
        for (int i = 0; i < SB + 4; i++) bb[i] = 8'h00;
        bb[0] = l16[7:0];
        bb[1] = l16[15:8];
        for (int i = 0; i < n; i++) bb[2 + i] = pay[i];
        for (int k = 0; k < 4; k++) bb[2 + n + k] = c[8*k +: 8];
        for (int w = 0; w < nw; w++) exp_w.push_back({bb[4*w+3], bb[4*w+2], bb[4*w+1], bb[4*w]});
        exp_n.push_back(nw);
    endtask

    task automatic fill_random(input int n);
        for (int i = 0; i < n; i++) pay[i] = 8'($urandom);
    endtask

    // Sends n bytes from pay[] and waits for the commit window to pass.
    task automatic send(input int n, input bit accept);
        int p0 = int'(pending);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == n - 1) chk(int'(pending) == p0, "R11 no early commit", pending, p0);
            rx_valid = 1'b1;
            rx_data  = pay[i];
            rx_last  = (i == n - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_last  = 1'b0;
        repeat (8) @(negedge clk);
        if (accept) expect_frame(n);
    endtask

    task automatic read_word(output logic [31:0] w);
        @(negedge clk);
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
        w = rd_data;
        chk(rd_valid == 1'b1, "R6 rd_valid", rd_valid, 1);
    endtask

    task automatic ctl_write(input logic [7:0] v);
        @(negedge clk);
        ctl_wr = 1'b1;
        ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    // Reads one whole packet and compares it with the model.
    task automatic drain_one(input string tag);
        logic [31:0] w;
        logic [31:0] e;
        int p0 = int'(pending);
        int nw = exp_n.pop_front();
        for (int i = 0; i < nw; i++) begin
            read_word(w);
            e = exp_w.pop_front();
            chk(w == e, tag, w, e);
        end
        chk(int'(pending) == p0 - 1, "R6 pending decrement", pending, p0 - 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pending == '0, "reset pending", pending, 0);
        chk(irq_rx == 1'b0, "reset irq_rx", irq_rx, 0);
        chk(ctl_q == 8'h00, "reset ctl_q", ctl_q, 0);

        // R7: empty read gives zero and leaves the count at zero.
        read_word(w);
        chk(w == 32'h0, "R7 empty read data", w, 0);
        chk(pending == '0, "R7 empty read pending", pending, 0);

        // R1: frame ignored while reception is off.
        fill_random(10);
        send(10, 1'b0);
        chk(pending == '0, "R1 disabled drop pending", pending, 0);
        chk(irq_rx == 1'b0, "R1 disabled drop irq", irq_rx, 0);

        ctl_write(8'h01);
        // R3 R4 R5: short frames that give every tail fill.
        for (int n = 1; n <= 6; n++) begin
            fill_random(n);
            send(n, 1'b1);
            chk(pending == PEND_W'(1), "R8 pending after store", pending, 1);
            chk(irq_rx == 1'b1, "R8 irq set", irq_rx, 1);
            drain_one("R3 R4 R5 short frame word");
        end
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        chk(irq_rx == 1'b0, "R8 irq ack clears", irq_rx, 0);

        // R2: fill every slot (the read slot has moved, so the indices wrap), then overflow.
        for (int f = 0; f < NS; f++) begin
            int n = 1 + int'($urandom_range(0, 15));
            fill_random(n);
            send(n, 1'b1);
        end
        chk(pending == PEND_W'(NS), "R2 full count", pending, NS);
        fill_random(8);
        send(8, 1'b0);
        chk(pending == PEND_W'(NS), "R2 full drop", pending, NS);
        for (int f = 0; f < NS; f++) drain_one("R6 wrap drain word");
        read_word(w);
        chk(w == 32'h0, "R7 read after drain", w, 0);

        // R10: one byte over the limit is dropped; exactly the limit is kept.
        fill_random(SB - 5);
        send(SB - 5, 1'b0);
        chk(pending == '0, "R10 oversize dropped", pending, 0);
        send(SB - 6, 1'b1);
        chk(exp_n[0] == SB / 4, "R10 max words", exp_n[0], SB / 4);
        drain_one("R10 max frame word");

        // R9: flush abandons a partly read packet and another one waiting.
        fill_random(20);
        send(20, 1'b1);
        fill_random(9);
        send(9, 1'b1);
        read_word(w);
        ctl_write(8'h11);
        chk(pending == '0, "R9 flush pending", pending, 0);
        chk(ctl_q == 8'h01, "R9 flush bit reads zero", ctl_q, 8'h01);
        exp_w.delete();
        exp_n.delete();
        fill_random(13);
        send(13, 1'b1);
        drain_one("R9 first frame after flush");

        // Random frames, sometimes two queued before draining.
        for (int it = 0; it < 14; it++) begin
            int n = 1 + int'($urandom_range(0, 79));
            fill_random(n);
            send(n, 1'b1);
            if (it % 3 == 0) begin
                int m = 1 + int'($urandom_range(0, 30));
                fill_random(m);
                send(m, 1'b1);
                chk(pending == PEND_W'(2), "R8 two stored", pending, 2);
                drain_one("R3 R4 random word");
            end
            drain_one("R3 R4 R5 random word");
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule